// File: doc/BRIEF.md
# Staged-Latch General-Purpose I/O Port

This block is a byte-wide general-purpose I/O port for a processor subsystem. Each pin has its own mode: output, bidirectional, or alternate-function output. Each pin also has its own drive type, push-pull or open-drain. The processor writes a master data latch over a small register bus. Reading the data address returns an input latch, not the master latch.

Two strobes from the processor core control when data moves between the latches. An instruction-start strobe samples the pad level into the input latch for bidirectional and alternate-function pins. An instruction-end strobe moves master data into the slave latch, and the slave latch drives the pad. A bidirectional read therefore returns the pin level. As a result, a read-modify-write of the port can clear bits that an outside device holds low. Software avoids this by keeping a shadow copy of the port and writing that copy with a plain load.

In alternate-function mode, a peripheral signal loads the slave latch on every clock. A pin with no peripheral attached drives high in push-pull mode and releases in open-drain mode. The pad side is made of four per-pin signals: pin level in, drive value, output enable and pull-up enable.

Top module: `gpio_port`

## Requirements
- R1: After synchronous reset, every pin is in output mode with push-pull drive and master data 0. The pins then show pad_out=00h, pad_oe=FFh and pad_pu=00h, and a read of the data address (0) returns 00h.
- R2: A write to the data address (0) changes only the master latch. The pads do not change until the next instr_end pulse. When several writes fall before that pulse, the last one is used.
- R3: For a pin in output mode (mode code 00), each instr_end copies the master bit into both the slave latch and the input latch. With push-pull drive, pad_out equals the slave bit and pad_oe is 1.
- R4: With open-drain drive (drive bit 1), pad_out is 0 and pad_oe is the inverse of the slave bit. A 1 therefore releases the pin, and the pad is never driven high.
- R5: For a pin in bidirectional mode (mode code 01), instr_start samples pin_in into the input latch and instr_end copies the master bit into the slave latch. The pin always uses open-drain drive, whatever its drive bit.
- R6: For a pin in alternate-function mode (mode code 10), the slave latch loads periph_out on every clock when periph_conn is 1, and loads 1 when periph_conn is 0. instr_start samples pin_in into the input latch. Writes to the master latch have no effect on the pad.
- R7: Mode code 11 behaves exactly like output mode.
- R8: pad_pu equals the pin's pull-up bit in bidirectional mode and is 0 in every other mode.
- R9: Take a bidirectional port with master 0Fh, pull-ups on, and pins 3 and 2 held low outside. A read then returns 03h. Writing back that value OR 80h makes the slave latch 83h, which shows as pad_oe=7Ch. Writing 8Fh instead from a shadow copy keeps bits 3 and 2 released.
- R10: The configuration registers read back at their addresses. Address 1 holds the low mode bit of each pin, address 2 the high mode bit, address 3 the drive type (1 = open-drain) and address 4 the pull-up enables. Other addresses read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| instr_start | input | 1 | Instruction-start strobe, samples pins |
| instr_end | input | 1 | Instruction-end strobe, moves master data to slave |
| periph_out | input | 8 | Per-pin peripheral drive value |
| periph_conn | input | 8 | Per-pin flag: a peripheral is attached |
| pin_in | input | 8 | Per-pin pad level |
| pad_out | output | 8 | Per-pin drive value |
| pad_oe | output | 8 | Per-pin output enable |
| pad_pu | output | 8 | Per-pin weak pull-up enable |

## Verification
Some rules are checked by assertions on every cycle. The slave latch holds between instr_end pulses outside alternate-function mode, and output mode copies master data on instr_end. Bidirectional and alternate-function pins sample the pin on instr_start. An unconnected alternate-function pin loads 1, an open-drain pad never drives high, pull-up enable appears only in bidirectional mode, and each data write lands in the master latch.

Other behaviour only the bench scenarios can show. These include the read-modify-write hazard with outside devices holding pins low, the shadow-copy fix, the last write winning within one instruction, and configuration read-back.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE0 = 3'd1;
    localparam logic [ADDR_W-1:0] A_MODE1 = 3'd2;
    localparam logic [ADDR_W-1:0] A_DRIVE = 3'd3;
    localparam logic [ADDR_W-1:0] A_PULL  = 3'd4;

    typedef enum logic [1:0] {
        PM_OUT   = 2'b00,
        PM_BIDIR = 2'b01,
        PM_ALT   = 2'b10
    } pin_mode_e;

    typedef struct packed {
        logic [1:0] mode_code;
        logic       open_drain;
        logic       pull_en;
        logic       master;
    } pin_cfg_t;

    // Code 11 is reserved and folds onto output mode.
    function automatic pin_mode_e decode_mode(input logic [1:0] code);
        case (code)
            2'b01:   return PM_BIDIR;
            2'b10:   return PM_ALT;
            default: return PM_OUT;
        endcase
    endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic [WIDTH-1:0]  in_latch,
    output logic [WIDTH-1:0]  master_q,
    output logic [WIDTH-1:0]  mode0_q,
    output logic [WIDTH-1:0]  mode1_q,
    output logic [WIDTH-1:0]  drive_q,
    output logic [WIDTH-1:0]  pull_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            master_q <= '0;
            mode0_q  <= '0;
            mode1_q  <= '0;
            drive_q  <= '0;
            pull_q   <= '0;
        end else if (bus_wr) begin
            case (bus_addr)
                A_DATA:  master_q <= bus_wdata;
                A_MODE0: mode0_q  <= bus_wdata;
                A_MODE1: mode1_q  <= bus_wdata;
                A_DRIVE: drive_q  <= bus_wdata;
                A_PULL:  pull_q   <= bus_wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (bus_addr)
            A_DATA:  bus_rdata = in_latch;
            A_MODE0: bus_rdata = mode0_q;
            A_MODE1: bus_rdata = mode1_q;
            A_DRIVE: bus_rdata = drive_q;
            A_PULL:  bus_rdata = pull_q;
            default: bus_rdata = '0;
        endcase
    end

    assert_master_write_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == A_DATA) |=> (master_q == $past(bus_wdata)));
endmodule

// File: rtl/gpio_bit_slice.sv
module gpio_bit_slice
    import gpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  pin_cfg_t cfg,
    input  logic     instr_start,
    input  logic     instr_end,
    input  logic     periph_out,
    input  logic     periph_conn,
    input  logic     pin_in,
    output logic     in_latch,
    output logic     pad_out,
    output logic     pad_oe,
    output logic     pad_pu
);
    pin_mode_e mode;
    logic      slave_q;
    logic      od_eff;

    assign mode = decode_mode(cfg.mode_code);

    always_ff @(posedge clk) begin
        if (rst) begin
            slave_q  <= 1'b0;
            in_latch <= 1'b0;
        end else begin
            case (mode)
                PM_BIDIR: begin
                    if (instr_start) in_latch <= pin_in;
                    if (instr_end)   slave_q  <= cfg.master;
                end
                PM_ALT: begin
                    if (instr_start) in_latch <= pin_in;
                    slave_q <= periph_conn ? periph_out : 1'b1;
                end
                default: begin
                    if (instr_end) begin
                        slave_q  <= cfg.master;
                        in_latch <= cfg.master;
                    end
                end
            endcase
        end
    end

    always_comb begin
        od_eff  = (mode == PM_BIDIR) || cfg.open_drain;
        pad_out = od_eff ? 1'b0 : slave_q;
        pad_oe  = od_eff ? ~slave_q : 1'b1;
        pad_pu  = (mode == PM_BIDIR) && cfg.pull_en;
    end

    assert_slave_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!instr_end && mode != PM_ALT) |=> $stable(slave_q));

    assert_out_copy_R3: assert property (@(posedge clk) disable iff (rst)
        (instr_end && mode == PM_OUT) |=>
            (slave_q == $past(cfg.master) && in_latch == $past(cfg.master)));

    assert_od_no_high_R4: assert property (@(posedge clk) disable iff (rst)
        od_eff |-> !(pad_oe && pad_out));

    assert_pin_sample_R5: assert property (@(posedge clk) disable iff (rst)
        (instr_start && (mode == PM_BIDIR || mode == PM_ALT)) |=>
            (in_latch == $past(pin_in)));

    assert_alt_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == PM_ALT && !periph_conn) |=> slave_q);

    assert_pull_bidir_only_R8: assert property (@(posedge clk) disable iff (rst)
        pad_pu |-> (cfg.mode_code == 2'b01));
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    input  logic              instr_start,
    input  logic              instr_end,
    input  logic [WIDTH-1:0]  periph_out,
    input  logic [WIDTH-1:0]  periph_conn,
    input  logic [WIDTH-1:0]  pin_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu
);
    logic [WIDTH-1:0] in_latch;
    logic [WIDTH-1:0] master_q, mode0_q, mode1_q, drive_q, pull_q;

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .in_latch  (in_latch),
        .master_q  (master_q),
        .mode0_q   (mode0_q),
        .mode1_q   (mode1_q),
        .drive_q   (drive_q),
        .pull_q    (pull_q)
    );

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        pin_cfg_t cfg;
        always_comb begin
            cfg.mode_code  = {mode1_q[i], mode0_q[i]};
            cfg.open_drain = drive_q[i];
            cfg.pull_en    = pull_q[i];
            cfg.master     = master_q[i];
        end

        gpio_bit_slice u_slice (
            .clk         (clk),
            .rst         (rst),
            .cfg         (cfg),
            .instr_start (instr_start),
            .instr_end   (instr_end),
            .periph_out  (periph_out[i]),
            .periph_conn (periph_conn[i]),
            .pin_in      (pin_in[i]),
            .in_latch    (in_latch[i]),
            .pad_out     (pad_out[i]),
            .pad_oe      (pad_oe[i]),
            .pad_pu      (pad_pu[i])
        );
    end
endmodule

// File: tb/sim_gpio_port.sv
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       instr_start = 1'b0;
    logic       instr_end = 1'b0;
    logic [7:0] periph_out = '0;
    logic [7:0] periph_conn = '0;
    logic [7:0] pin_in;
    logic [7:0] pad_out, pad_oe, pad_pu;
    logic [7:0] hold_low = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    // Pad model: an outside device may hold a pin low; an undriven pin reads high.
    always_comb begin
        for (int i = 0; i < 8; i++)
            pin_in[i] = hold_low[i] ? 1'b0 : (pad_oe[i] ? pad_out[i] : 1'b1);
    end

    gpio_port u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .instr_start(instr_start), .instr_end(instr_end),
        .periph_out(periph_out), .periph_conn(periph_conn), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_end();
        @(negedge clk); instr_end = 1'b1;
        @(negedge clk); instr_end = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); instr_start = 1'b1;
        @(negedge clk); instr_start = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check("R1 pad_out", pad_out, 8'h00);
        check("R1 pad_oe", pad_oe, 8'hFF);
        check("R1 pad_pu", pad_pu, 8'h00);
        rd(3'd0, v);
        check("R1 read data", v, 8'h00);
    endtask

    task automatic t_staging();
        logic [7:0] v;
        wr(3'd0, 8'h55);
        wr(3'd0, 8'hA5);
        check("R2 pad held before end", pad_out, 8'h00);
        pulse_end();
        check("R2 R3 last write on pad", pad_out, 8'hA5);
        check("R3 push-pull oe", pad_oe, 8'hFF);
        rd(3'd0, v);
        check("R3 input latch copy", v, 8'hA5);
    endtask

    task automatic t_open_drain();
        wr(3'd3, 8'hFF);
        @(negedge clk);
        check("R4 od pad_out", pad_out, 8'h00);
        check("R4 od pad_oe", pad_oe, 8'h5A);
        wr(3'd3, 8'h00);
    endtask

    task automatic t_reserved();
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'hFF);
        wr(3'd0, 8'h3C);
        check("R7 held before end", pad_out, 8'hA5);
        pulse_end();
        check("R7 reserved as output", pad_out, 8'h3C);
        check("R7 oe", pad_oe, 8'hFF);
        check("R8 no pull in code 11", pad_pu, 8'h00);
    endtask

    task automatic t_bidir_rmw();
        logic [7:0] v;
        wr(3'd1, 8'hFF);
        wr(3'd2, 8'h00);
        wr(3'd4, 8'hFF);
        wr(3'd3, 8'h00);
        wr(3'd0, 8'h0F);
        pulse_end();
        check("R8 pull in bidir", pad_pu, 8'hFF);
        check("R5 bidir forced open-drain", pad_out, 8'h00);
        check("R5 oe from slave", pad_oe, 8'hF0);
        hold_low = 8'h0C;
        pulse_start();
        rd(3'd0, v);
        check("R5 R9 pin read", v, 8'h03);
        wr(3'd0, v | 8'h80);
        pulse_end();
        check("R9 rmw slave 83h", pad_oe, 8'h7C);
        pulse_start();
        rd(3'd0, v);
        check("R9 pin after rmw", v, 8'h83);
        wr(3'd0, 8'h8F);
        pulse_end();
        check("R9 shadow load", pad_oe, 8'h70);
        hold_low = 8'h00;
        pulse_start();
        rd(3'd0, v);
        check("R9 released bits", v, 8'h8F);
    endtask

    task automatic t_alt();
        logic [7:0] v;
        wr(3'd1, 8'h00);
        wr(3'd2, 8'hFF);
        periph_conn = 8'hF0;
        periph_out  = 8'hA0;
        @(negedge clk);
        check("R6 alt push-pull", pad_out, 8'hAF);
        check("R8 no pull in alt", pad_pu, 8'h00);
        periph_out = 8'h50;
        @(negedge clk);
        check("R6 peripheral follows", pad_out, 8'h5F);
        wr(3'd3, 8'hFF);
        check("R6 R4 alt open-drain oe", pad_oe, 8'hA0);
        pulse_start();
        rd(3'd0, v);
        check("R6 alt pin sample", v, 8'h5F);
        wr(3'd0, 8'h00);
        pulse_end();
        check("R6 master ignored in alt", pad_oe, 8'hA0);
    endtask

    task automatic t_readback();
        logic [7:0] v;
        rd(3'd1, v); check("R10 mode0", v, 8'h00);
        rd(3'd2, v); check("R10 mode1", v, 8'hFF);
        rd(3'd3, v); check("R10 drive", v, 8'hFF);
        rd(3'd4, v); check("R10 pull", v, 8'hFF);
        rd(3'd6, v); check("R10 unused", v, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_staging();
        t_open_drain();
        t_reserved();
        t_bidir_rmw();
        t_alt();
        t_readback();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #100000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule